// File: doc/BRIEF.md
# Synchronous Three-Wire Serial Shifter

This block moves one byte at a time over a three-wire synchronous serial link made of a data-out pin, a data-in pin and a shift clock. One 8-bit register does both jobs. Its most significant bit drives the serial output. Bits taken from the serial input enter at the low end. After a full exchange, the byte that was sent has been replaced by the byte that was received.

The block runs in one of two modes. As a master it makes the shift clock itself by counting a one-cycle instruction-cycle strobe, and it always starts the exchange. As a slave it follows a shift clock from outside, which it first synchronises to the system clock. The system clock must run at least four times faster than that external clock.

A host controls the block through a small register port with three addresses. Address 0 is the data register. Address 1 is the configuration register. Address 2 is the busy flag. Writing the busy flag to one starts a transfer. The flag drops by itself after eight bits. The host may also clear it early to stop a transfer partway through a byte.

Top module: `sync_shift_port`

## Requirements
- R1: After reset, every host-readable register reads zero. The shift clock, the serial output and the pin-claim output are all low.
- R2: Configuration register (address 1), bit 0, is the enable. The pin-claim output follows this bit. While it is zero, a write of one to the busy flag is ignored and the busy flag stays zero.
- R3: Configuration register bits 3:2 select the master clock rate. Code 00 gives a full shift-clock period of 2 instruction-cycle strobes. Code 01 gives 4 strobes. Codes 10 and 11 both give 8 strobes. The shift clock only rises in a cycle that follows a strobe.
- R4: In master mode (configuration bit 1 set), data leaves MSB first. The serial output changes on the falling shift-clock edge. The serial input is sampled on the rising edge. After eight bits, the data register holds the eight sampled bits, with the first one in the MSB.
- R5: The busy flag is bit 0 of address 2. Writing one to it while it is idle and the block is enabled starts a transfer. The flag rises only in response to such a write. It clears itself on the eighth falling shift-clock edge.
- R6: Writing zero to the busy flag stops shifting at once. The shift clock drops to low, and the partly shifted byte stays in the data register unchanged.
- R7: In slave mode (configuration bit 1 clear), the block shifts only on edges of the external clock, and only while busy. The shift-clock output stays low. When not busy, the block ignores edges of the external clock.
- R8: A write to the data register (address 0) is ignored while busy. A read of address 0 returns the current contents of the shift register.
- R9: When not busy, the shift-clock output is low and the serial output shows the MSB of the data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cycleTick | input | 1 | One-cycle instruction-cycle strobe |
| hostWrEn | input | 1 | Host write strobe |
| hostAddr | input | 2 | Host register address |
| hostWrData | input | DATA_W | Host write data |
| hostRdData | output | DATA_W | Host read data for hostAddr |
| serIn | input | 1 | Serial data input |
| serOut | output | 1 | Serial data output |
| sclkIn | input | 1 | External shift clock (slave mode) |
| sclkOut | output | 1 | Generated shift clock (master mode) |
| pinsClaimed | output | 1 | High while enabled; hands serOut and the clock pin to the block |

## Verification
Most internal faults in this block appear at the pins within one shift-clock period. A wrong divider count stretches or shortens the next gap between rising edges of sclkOut. A wrong bit count shows up when the busy flag drops after the wrong number of falling edges, and the read-back byte is misaligned as a result. A sampling or shifting fault on the wrong edge corrupts either the byte seen on serOut or the byte read back from address 0 by the end of that same transfer. Early-stop, disable and idle-slave faults are caught through the host port. In each case the byte left behind, or a busy flag that should have stayed low, is visible within a few cycles of the stimulus.

// File: rtl/sync_shift_pkg.sv
package sync_shift_pkg;

  typedef struct packed {
    logic loadData;
    logic sampleIn;
    logic shiftOut;
  } dpStrobe_t;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_CFG  = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  localparam int CFG_EN_BIT     = 0;
  localparam int CFG_MASTER_BIT = 1;
  localparam int CFG_RATE_LSB   = 2;
  localparam int CFG_BITS       = 4;

  localparam int DIV_W = 3;

  // Strobes per half period of the master shift clock.
  function automatic logic [DIV_W-1:0] halfTicks(input logic [1:0] rateCode);
    logic [DIV_W-1:0] h;
    if (rateCode[1])      h = 3'd4;
    else if (rateCode[0]) h = 3'd2;
    else                  h = 3'd1;
    return h;
  endfunction

endpackage

// File: rtl/sync_shift_datapath.sv
module sync_shift_datapath
  import sync_shift_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] loadValue,
  input  logic              serIn,
  output logic [DATA_W-1:0] shiftReg,
  output logic              serOut
);

  logic sampleBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg  <= '0;
      sampleBit <= 1'b0;
    end else begin
      if (strobe.sampleIn) sampleBit <= serIn;
      if (strobe.loadData)
        shiftReg <= loadValue;
      else if (strobe.shiftOut)
        shiftReg <= {shiftReg[DATA_W-2:0], sampleBit};
    end
  end

  assign serOut = shiftReg[DATA_W-1];

endmodule

// File: rtl/sync_shift_ctrl.sv
module sync_shift_ctrl
  import sync_shift_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cycleTick,
  input  logic                hostWrEn,
  input  logic [1:0]          hostAddr,
  input  logic [CFG_BITS-1:0] hostCtlBits,
  input  logic                sclkIn,
  output dpStrobe_t           strobe,
  output logic                sclkOut,
  output logic                busy,
  output logic                enable,
  output logic                master,
  output logic [1:0]          rateSel
);

  localparam int BIT_CNT_W = $clog2(DATA_W);
  localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(DATA_W - 1);

  logic [1:0]           syncQ;
  logic                 sclkInPrev;
  logic [DIV_W-1:0]     divCnt;
  logic [BIT_CNT_W-1:0] bitCnt;
  logic                 sclkQ;

  logic cfgWrite, statWrite, dataWrite;
  logic enableNext, startReq, stopReq;
  logic [DIV_W-1:0] halfLimit;
  logic tickHit, slaveRise, slaveFall;
  logic riseEv, fallEv, sampleEv, shiftEv;
  logic busyNext;

  always_comb begin
    cfgWrite   = hostWrEn && (hostAddr == ADDR_CFG);
    statWrite  = hostWrEn && (hostAddr == ADDR_STAT);
    dataWrite  = hostWrEn && (hostAddr == ADDR_DATA);
    enableNext = cfgWrite ? hostCtlBits[CFG_EN_BIT] : enable;
    startReq   = statWrite && hostCtlBits[0] && !busy && enable && enableNext;
    stopReq    = statWrite && !hostCtlBits[0];
    halfLimit  = halfTicks(rateSel) - 3'd1;
    tickHit    = busy && master && cycleTick && (divCnt == halfLimit);
    slaveRise  = busy && !master && syncQ[1] && !sclkInPrev;
    slaveFall  = busy && !master && !syncQ[1] && sclkInPrev;
    riseEv     = master ? (tickHit && !sclkQ) : slaveRise;
    fallEv     = master ? (tickHit && sclkQ) : slaveFall;
    sampleEv   = riseEv && !stopReq;
    shiftEv    = fallEv && !stopReq;

    if (!enableNext)                       busyNext = 1'b0;
    else if (startReq)                     busyNext = 1'b1;
    else if (stopReq)                      busyNext = 1'b0;
    else if (shiftEv && bitCnt == LAST_BIT) busyNext = 1'b0;
    else                                   busyNext = busy;

    strobe.loadData = dataWrite && !busy;
    strobe.sampleIn = sampleEv;
    strobe.shiftOut = shiftEv;
  end

  // External clock synchroniser and edge history.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ      <= '0;
      sclkInPrev <= 1'b0;
    end else begin
      syncQ      <= {syncQ[0], sclkIn};
      sclkInPrev <= syncQ[1];
    end
  end

  // Configuration register.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enable  <= 1'b0;
      master  <= 1'b0;
      rateSel <= 2'b00;
    end else if (cfgWrite) begin
      enable  <= hostCtlBits[CFG_EN_BIT];
      master  <= hostCtlBits[CFG_MASTER_BIT];
      rateSel <= hostCtlBits[CFG_RATE_LSB +: 2];
    end
  end

  // Transfer sequencing: busy, bit count, divider, shift clock.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      bitCnt <= '0;
      divCnt <= '0;
      sclkQ  <= 1'b0;
    end else begin
      busy <= busyNext;

      if (startReq)     bitCnt <= '0;
      else if (shiftEv) bitCnt <= bitCnt + 1'b1;

      if (startReq || tickHit)            divCnt <= '0;
      else if (busy && master && cycleTick) divCnt <= divCnt + 1'b1;

      if (!busyNext || startReq) sclkQ <= 1'b0;
      else if (tickHit)          sclkQ <= ~sclkQ;
    end
  end

  assign sclkOut = sclkQ;

endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port
  import sync_shift_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cycleTick,
  input  logic              hostWrEn,
  input  logic [1:0]        hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [DATA_W-1:0] hostRdData,
  input  logic              serIn,
  output logic              serOut,
  input  logic              sclkIn,
  output logic              sclkOut,
  output logic              pinsClaimed
);

  dpStrobe_t         strobe;
  logic [DATA_W-1:0] shiftData;
  logic              busyFlag, enableFlag, masterFlag;
  logic [1:0]        rateCode;

  sync_shift_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cycleTick  (cycleTick),
    .hostWrEn   (hostWrEn),
    .hostAddr   (hostAddr),
    .hostCtlBits(hostWrData[CFG_BITS-1:0]),
    .sclkIn     (sclkIn),
    .strobe     (strobe),
    .sclkOut    (sclkOut),
    .busy       (busyFlag),
    .enable     (enableFlag),
    .master     (masterFlag),
    .rateSel    (rateCode)
  );

  sync_shift_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .loadValue(hostWrData),
    .serIn    (serIn),
    .shiftReg (shiftData),
    .serOut   (serOut)
  );

  always_comb begin
    hostRdData = '0;
    case (hostAddr)
      ADDR_DATA: hostRdData = shiftData;
      ADDR_CFG: begin
        hostRdData[CFG_EN_BIT]          = enableFlag;
        hostRdData[CFG_MASTER_BIT]      = masterFlag;
        hostRdData[CFG_RATE_LSB +: 2]   = rateCode;
      end
      ADDR_STAT: hostRdData[0] = busyFlag;
      default:   hostRdData = '0;
    endcase
  end

  assign pinsClaimed = enableFlag;

endmodule

// File: rtl/sync_shift_port_checker.sv
module sync_shift_port_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cycleTick,
  input logic              hostWrEn,
  input logic [1:0]        hostAddr,
  input logic              hostWrBit0,
  input logic              sclkOut,
  input logic              busy,
  input logic              enable,
  input logic              master,
  input logic              loadData,
  input logic [DATA_W-1:0] shiftReg
);

  assert_disabled_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> !busy);

  assert_rise_on_tick_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclkOut) |-> $past(cycleTick));

  assert_start_by_host_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(hostWrEn && hostAddr == 2'd2 && hostWrBit0));

  assert_frozen_when_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !loadData) |=> $stable(shiftReg));

  assert_slave_clk_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    !master |-> !sclkOut);

  assert_idle_clk_low_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sclkOut);

endmodule

bind sync_shift_port sync_shift_port_checker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cycleTick (cycleTick),
  .hostWrEn  (hostWrEn),
  .hostAddr  (hostAddr),
  .hostWrBit0(hostWrData[0]),
  .sclkOut   (sclkOut),
  .busy      (busyFlag),
  .enable    (enableFlag),
  .master    (masterFlag),
  .loadData  (strobe.loadData),
  .shiftReg  (shiftData)
);

// File: tb/sync_shift_port_bench.sv
`timescale 1ns/1ps
module sync_shift_port_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cycleTick = 1'b0;
  logic       hostWrEn = 1'b0;
  logic [1:0] hostAddr = 2'd0;
  logic [7:0] hostWrData = 8'h00;
  logic [7:0] hostRdData;
  logic       serIn, serOut, sclkIn, sclkOut, pinsClaimed;

  logic slaveMode = 1'b0;
  logic slaveSerIn = 1'b0;
  logic masterSerIn = 1'b0;
  logic sclkDrive = 1'b0;

  assign serIn  = slaveMode ? slaveSerIn : masterSerIn;
  assign sclkIn = sclkDrive;

  always #5 clk = ~clk;

  sync_shift_port u_sync_shift_port (
    .clk(clk), .rstN(rstN), .cycleTick(cycleTick),
    .hostWrEn(hostWrEn), .hostAddr(hostAddr), .hostWrData(hostWrData),
    .hostRdData(hostRdData), .serIn(serIn), .serOut(serOut),
    .sclkIn(sclkIn), .sclkOut(sclkOut), .pinsClaimed(pinsClaimed)
  );

  int total = 0;
  int failed = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Strobe generator and shift-clock monitor, all at the falling system edge.
  int   tickPh = 0;
  int   cycNum = 0;
  logic prevSclk = 1'b0;
  logic [7:0] inPat = 8'h00;
  logic [7:0] rxByte = 8'h00;
  int   fallCnt = 0, riseCnt = 0, lastRise = 0, lastGap = 0;
  bit   riseSeen = 0;

  always @(negedge clk) begin
    cycNum++;
    if (sclkOut && !prevSclk) begin
      rxByte = {rxByte[6:0], serOut};
      if (riseSeen) lastGap = cycNum - lastRise;
      lastRise = cycNum;
      riseSeen = 1;
      riseCnt++;
    end
    if (!sclkOut && prevSclk) fallCnt++;
    prevSclk = sclkOut;
    masterSerIn = (fallCnt < 8) ? inPat[7 - fallCnt] : 1'b0;
    cycleTick = (tickPh == 2);
    tickPh = (tickPh + 1) % 3;
  end

  task automatic armMonitor(input logic [7:0] pat);
    @(posedge clk);
    inPat = pat;
    rxByte = 8'h00;
    fallCnt = 0;
    riseCnt = 0;
    riseSeen = 0;
    lastGap = 0;
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    hostWrEn = 1'b1; hostAddr = a; hostWrData = d;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    hostAddr = a;
    #1 d = hostRdData;
  endtask

  task automatic waitIdle();
    logic [7:0] st;
    for (int i = 0; i < 3000; i++) begin
      readReg(2'd2, st);
      if (!st[0]) break;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failed++; total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic [7:0] outPat, inP, expRx;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int a = 0; a < 3; a++) begin
      readReg(a[1:0], rd);
      check(rd == 8'h00, "R1 reset register", rd, 0);
    end
    check(!sclkOut && !serOut && !pinsClaimed, "R1 pins after reset",
          {sclkOut, serOut, pinsClaimed}, 0);

    // R2 disabled block ignores start
    writeReg(2'd0, 8'h96);
    armMonitor(8'hFF);
    writeReg(2'd2, 8'h01);
    readReg(2'd2, rd);
    check(rd[0] == 1'b0, "R2 busy stays low when disabled", rd[0], 0);
    repeat (40) @(negedge clk);
    check(riseCnt == 0, "R2 no shift clock when disabled", riseCnt, 0);
    readReg(2'd0, rd);
    check(rd == 8'h96, "R2 data untouched when disabled", rd, 8'h96);
    check(pinsClaimed == 1'b0, "R2 pins not claimed", pinsClaimed, 0);

    // Master sweep over all rate codes and several patterns (R3 R4 R5 R8 R9)
    for (int r = 0; r < 4; r++) begin
      for (int k = 0; k < 3; k++) begin
        int expGap;
        outPat = 8'hA5 ^ 8'(r * 37 + k * 91);
        inP    = {outPat[3:0], ~outPat[7:4]} ^ 8'(k * 17);
        expGap = ((r >= 2) ? 8 : (r == 1 ? 4 : 2)) * 3;
        writeReg(2'd1, {4'b0, r[1:0], 2'b11});
        check(pinsClaimed == 1'b1, "R2 pins claimed when enabled", pinsClaimed, 1);
        writeReg(2'd0, outPat);
        readReg(2'd0, rd);
        check(rd == outPat, "R8 idle data readback", rd, outPat);
        check(serOut == outPat[7] && !sclkOut, "R9 idle MSB on output, clock low",
              {sclkOut, serOut}, {1'b0, outPat[7]});
        armMonitor(inP);
        writeReg(2'd2, 8'h01);
        readReg(2'd2, rd);
        check(rd[0] == 1'b1, "R5 busy set by start write", rd[0], 1);
        if (k == 1) writeReg(2'd0, 8'h5A); // R8 blocked write mid-transfer
        waitIdle();
        check(rxByte == outPat, "R4 bits out MSB first", rxByte, outPat);
        readReg(2'd0, rd);
        check(rd == inP, "R4 received byte in register", rd, inP);
        check(fallCnt == 8, "R5 busy clears after eight bits", fallCnt, 8);
        check(lastGap == expGap, "R3 shift clock period", lastGap, expGap);
        check(!sclkOut, "R9 clock low after transfer", sclkOut, 0);
      end
    end

    // R6 early stop after three bits
    writeReg(2'd1, 8'h03);
    outPat = 8'hC3; inP = 8'h5A;
    writeReg(2'd0, outPat);
    armMonitor(inP);
    writeReg(2'd2, 8'h01);
    for (int i = 0; i < 500; i++) begin
      @(posedge clk);
      if (fallCnt >= 3) break;
    end
    writeReg(2'd2, 8'h00);
    repeat (50) @(negedge clk);
    expRx = {outPat[4:0], inP[7:5]};
    readReg(2'd0, rd);
    check(rd == expRx, "R6 partial byte kept", rd, expRx);
    readReg(2'd2, rd);
    check(rd[0] == 1'b0, "R6 busy cleared by host", rd[0], 0);
    check(fallCnt == 3 && !sclkOut, "R6 shifting stopped", fallCnt, 3);

    // R7 slave transfers
    slaveMode = 1'b1;
    for (int k = 0; k < 2; k++) begin
      logic [7:0] rx;
      outPat = k ? 8'h3E : 8'hD1;
      inP    = k ? 8'hB4 : 8'h69;
      writeReg(2'd1, 8'h01);
      writeReg(2'd0, outPat);
      armMonitor(8'h00);
      writeReg(2'd2, 8'h01);
      rx = 8'h00;
      for (int b = 0; b < 8; b++) begin
        slaveSerIn = inP[7 - b];
        repeat (6) @(negedge clk);
        rx = {rx[6:0], serOut};
        sclkDrive = 1'b1;
        repeat (6) @(negedge clk);
        sclkDrive = 1'b0;
      end
      repeat (10) @(negedge clk);
      check(rx == outPat, "R7 slave bits out", rx, outPat);
      readReg(2'd0, rd);
      check(rd == inP, "R7 slave byte received", rd, inP);
      readReg(2'd2, rd);
      check(rd[0] == 1'b0, "R7 slave busy self-clears", rd[0], 0);
      check(riseCnt == 0, "R7 no clock output in slave", riseCnt, 0);
    end

    // R7 idle slave ignores external clock
    readReg(2'd0, expRx);
    for (int b = 0; b < 5; b++) begin
      slaveSerIn = b[0];
      repeat (6) @(negedge clk); sclkDrive = 1'b1;
      repeat (6) @(negedge clk); sclkDrive = 1'b0;
    end
    repeat (8) @(negedge clk);
    readReg(2'd0, rd);
    check(rd == expRx, "R7 idle slave ignores clock", rd, expRx);

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

endmodule